// File: doc/BRIEF.md
# Generalized Bit Reverse Unit

This unit applies a generalized-reverse permutation to an XLEN-bit operand. A control value c, CW = log2(XLEN) bits wide, picks the permutation: each result bit i is taken from operand bit (i XOR c). The control can come from a register or an immediate, as decided upstream, and always arrives on one control input. The permutation is built as a chain of conditional swap stages. Stage k exchanges neighbouring groups of 2^k bits, and bit k of the control switches it on.

A small select field also offers two fixed forms. One reverses the bit order inside every byte. The other swaps the bytes end for end. It also offers a pass-through. The result goes into a register, and a valid flag follows the input strobe by one clock. XLEN is 32 or 64. At 32 the chain has five stages, and at 64 it has six.

Top module: `grev_unit`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and out_data is all zeros.
- R2: out_valid equals the value of in_valid one rising clock edge earlier.
- R3: With in_sel = 0 (controlled reverse), let c = in_ctrl[CW-1:0]. One edge after a strobe, out_data bit i equals in_data bit (i XOR c) for every i.
- R4: With in_sel = 0, bits of in_ctrl at position CW and above have no effect on out_data.
- R5: With in_sel = 1 (byte-wise bit reverse), out_data bit 8b+j equals in_data bit 8b+7-j for every byte b, and in_ctrl is ignored.
- R6: With in_sel = 2 (byte swap), out_data byte b equals in_data byte XLEN/8-1-b, and in_ctrl is ignored.
- R7: With in_sel = 3 (pass-through), out_data equals in_data, and in_ctrl is ignored.
- R8: When in_valid is 0 at an edge, out_data keeps its previous value.
- R9: With in_sel = 0, control c = 0 leaves the operand unchanged, and c = XLEN-1 reverses the full word bit for bit.
- R10: Every operation keeps the number of ones of the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: capture a result at this edge |
| in_sel | input | 2 | Operation: 0 controlled, 1 byte-wise bit reverse, 2 byte swap, 3 pass |
| in_ctrl | input | CTRL_IN_W | Control value, register or immediate sourced; low CW bits used |
| in_data | input | XLEN | Operand |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_data | output | XLEN | Registered permuted result |

## Verification
If a stage mask is wrong, or a stage is switched on by the wrong bit, the error shows up at out_data one clock after the strobe. It shows only for control values that enable that stage, so the bench sweeps all 32 control values with several random operands each. A wrong decode of the fixed forms shows up just as quickly, but only for operands whose bytes are not already symmetric, so those forms use random and directed asymmetric patterns. A broken capture enable shows up as out_data changing during idle cycles.

// File: rtl/grev_pkg.sv
package grev_pkg;

   typedef enum logic [1:0] {
      GRV_OP_CTRL  = 2'd0,
      GRV_OP_BREV8 = 2'd1,
      GRV_OP_BSWAP = 2'd2,
      GRV_OP_PASS  = 2'd3
   } grv_op_e;

   // Mask of stage k over a 64-bit lane: bit i is set when bit k of i is clear.
   function automatic logic [63:0] stage_mask(input int k);
      logic [63:0] m;
      for (int i = 0; i < 64; i++) begin
         m[i] = ((i >> k) & 1) == 0;
      end
      return m;
   endfunction

endpackage

// File: rtl/grev_ctrl_sel.sv
module grev_ctrl_sel
   import grev_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CW        = 5,
   parameter int CTRL_IN_W = 12
) (
   input  logic [1:0]           sel,
   input  logic [CTRL_IN_W-1:0] ctrl_in,
   output logic [CW-1:0]        ctrl_eff
);
   localparam logic [CW-1:0] BREV8_C = CW'(7);
   localparam logic [CW-1:0] BSWAP_C = CW'(XLEN - 8);

   generate
      if (CTRL_IN_W > CW) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^ctrl_in[CTRL_IN_W-1:CW];
      end
   endgenerate

   always_comb begin
      unique case (grv_op_e'(sel))
         GRV_OP_CTRL:  ctrl_eff = ctrl_in[CW-1:0];
         GRV_OP_BREV8: ctrl_eff = BREV8_C;
         GRV_OP_BSWAP: ctrl_eff = BSWAP_C;
         default:      ctrl_eff = '0;
      endcase
   end
endmodule

// File: rtl/grev_swap_stage.sv
module grev_swap_stage
   import grev_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int K    = 0
) (
   input  logic            en,
   input  logic [XLEN-1:0] x,
   output logic [XLEN-1:0] y
);
   localparam int              SHIFT = 1 << K;
   localparam logic [63:0]     MFULL = stage_mask(K);
   localparam logic [XLEN-1:0] MASK  = MFULL[XLEN-1:0];

   if (SHIFT >= XLEN) begin : g_bad_stage
      $error("grev_swap_stage: shift %0d not below width %0d", SHIFT, XLEN);
   end

   logic [XLEN-1:0] swapped;
   assign swapped = ((x & MASK) << SHIFT) | ((x & ~MASK) >> SHIFT);
   assign y       = en ? swapped : x;
endmodule

// File: rtl/grev_network.sv
module grev_network #(
   parameter int XLEN = 32,
   parameter int CW   = 5
) (
   input  logic [CW-1:0]   ctrl,
   input  logic [XLEN-1:0] x,
   output logic [XLEN-1:0] y
);
   logic [XLEN-1:0] chain [0:CW];

   assign chain[0] = x;

   for (genvar k = 0; k < CW; k++) begin : g_stage
      grev_swap_stage #(
         .XLEN (XLEN),
         .K    (k)
      ) u_stage (
         .en (ctrl[k]),
         .x  (chain[k]),
         .y  (chain[k+1])
      );
   end

   assign y = chain[CW];
endmodule

// File: rtl/grev_unit.sv
module grev_unit #(
   parameter int XLEN      = 32,
   parameter int CTRL_IN_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           in_sel,
   input  logic [CTRL_IN_W-1:0] in_ctrl,
   input  logic [XLEN-1:0]      in_data,
   output logic                 out_valid,
   output logic [XLEN-1:0]      out_data
);
   localparam int CW    = $clog2(XLEN);
   localparam int NBYTE = XLEN / 8;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("grev_unit: XLEN must be 32 or 64, got %0d", XLEN);
   end
   if (CTRL_IN_W < CW) begin : g_bad_ctrl
      $error("grev_unit: control input narrower than %0d bits", CW);
   end

   logic [CW-1:0]   ctrl_eff;
   logic [XLEN-1:0] perm;

   grev_ctrl_sel #(
      .XLEN      (XLEN),
      .CW        (CW),
      .CTRL_IN_W (CTRL_IN_W)
   ) u_sel (
      .sel      (in_sel),
      .ctrl_in  (in_ctrl),
      .ctrl_eff (ctrl_eff)
   );

   grev_network #(
      .XLEN (XLEN),
      .CW   (CW)
   ) u_net (
      .ctrl (ctrl_eff),
      .x    (in_data),
      .y    (perm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= perm;
         end
      end
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == 2'd3) |=> out_data == $past(in_data));
   a_r6_low_byte_from_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == 2'd2) |=> out_data[7:0] == $past(in_data[XLEN-1 -: 8]));
   a_r10_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $countones(out_data) == $countones($past(in_data)));
   a_r9_zero_ctrl_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == 2'd0 && in_ctrl[CW-1:0] == '0) |=> out_data == $past(in_data));

   logic unused_nbyte;
   assign unused_nbyte = (NBYTE == 0);
endmodule

// File: tb/grev_unit_tb.sv
module grev_unit_tb;
   localparam int XLEN = 32;
   localparam int CIW  = 12;
   localparam int CW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [1:0]      in_sel = 2'd0;
   logic [CIW-1:0]  in_ctrl = '0;
   logic [XLEN-1:0] in_data = '0;
   logic            out_valid;
   logic [XLEN-1:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   grev_unit #(.XLEN(XLEN), .CTRL_IN_W(CIW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
      .in_ctrl(in_ctrl), .in_data(in_data), .out_valid(out_valid),
      .out_data(out_data)
   );

   function automatic logic [XLEN-1:0] ref_grev(input logic [XLEN-1:0] x, input int c);
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = x[i ^ c];
      return r;
   endfunction

   function automatic logic [XLEN-1:0] ref_brev8(input logic [XLEN-1:0] x);
      logic [XLEN-1:0] r;
      for (int b = 0; b < XLEN/8; b++)
         for (int j = 0; j < 8; j++) r[8*b+j] = x[8*b+7-j];
      return r;
   endfunction

   function automatic logic [XLEN-1:0] ref_bswap(input logic [XLEN-1:0] x);
      logic [XLEN-1:0] r;
      for (int b = 0; b < XLEN/8; b++) r[8*b +: 8] = x[8*(XLEN/8-1-b) +: 8];
      return r;
   endfunction

   task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one strobe at a falling edge, sample the registered result at the next one.
   task automatic run_op(input logic [1:0] sel, input logic [CIW-1:0] ctrl,
                         input logic [XLEN-1:0] data, output logic [XLEN-1:0] res,
                         output logic vld);
      @(negedge clk);
      in_valid = 1'b1; in_sel = sel; in_ctrl = ctrl; in_data = data;
      @(negedge clk);
      res = out_data; vld = out_valid;
      in_valid = 1'b0;
   endtask

   initial begin
      logic [XLEN-1:0] r, r2, d;
      logic v;
      void'($urandom(32'd20211102));
      repeat (3) @(negedge clk);
      check("R1 reset valid", {31'd0, out_valid}, 32'd0);
      check("R1 reset data", out_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset data", out_data, 32'd0);

      // R3: sweep every control value with random operands and random upper bits
      for (int c = 0; c < 32; c++) begin
         for (int n = 0; n < 4; n++) begin
            d = $urandom();
            run_op(2'd0, CIW'(c), d, r, v);
            check($sformatf("R3 ctrl=%0d", c), r, ref_grev(d, c));
            check("R2 valid after strobe", {31'd0, v}, 32'd1);
         end
      end

      // R4: upper control bits ignored
      for (int n = 0; n < 6; n++) begin
         int c = $urandom_range(31);
         d = $urandom();
         run_op(2'd0, CIW'(c), d, r, v);
         run_op(2'd0, CIW'(c) | (CIW'($urandom()) << CW), d, r2, v);
         check("R4 upper ctrl ignored", r2, r);
      end

      // R9: identity and full reversal
      run_op(2'd0, 12'h000, 32'hDEADBEEF, r, v);
      check("R9 ctrl zero identity", r, 32'hDEADBEEF);
      run_op(2'd0, 12'h01F, 32'h00000001, r, v);
      check("R9 full reverse", r, 32'h80000000);
      run_op(2'd0, 12'h01F, 32'h12345678, r, v);
      check("R9 full reverse pattern", r, 32'h1E6A2C48);

      // R5: byte-wise bit reverse
      run_op(2'd1, 12'hFFF, 32'h01804F12, r, v);
      check("R5 brev8 directed", r, 32'h8001F248);
      for (int n = 0; n < 8; n++) begin
         d = $urandom();
         run_op(2'd1, CIW'($urandom()), d, r, v);
         check("R5 brev8 random", r, ref_brev8(d));
      end

      // R6: byte swap
      run_op(2'd2, 12'h000, 32'h11223344, r, v);
      check("R6 byte swap directed", r, 32'h44332211);
      for (int n = 0; n < 8; n++) begin
         d = $urandom();
         run_op(2'd2, CIW'($urandom()), d, r, v);
         check("R6 byte swap random", r, ref_bswap(d));
      end

      // R7: pass-through
      for (int n = 0; n < 6; n++) begin
         d = $urandom();
         run_op(2'd3, CIW'($urandom()), d, r, v);
         check("R7 pass", r, d);
      end

      // R10: ones kept across all operations
      for (int n = 0; n < 8; n++) begin
         d = $urandom();
         run_op(2'($urandom_range(3)), CIW'($urandom()), d, r, v);
         check("R10 ones count", 32'($countones(r)), 32'($countones(d)));
      end

      // R8 and R2: idle cycles hold the result and drop valid
      run_op(2'd0, 12'h003, 32'hA5A5_0F0F, r, v);
      @(negedge clk);
      in_sel = 2'd3; in_data = 32'hFFFF_0000; in_ctrl = 12'h0AB;
      @(negedge clk);
      check("R8 hold while idle", out_data, r);
      check("R2 valid low while idle", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      check("R8 hold second idle", out_data, r);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule